// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of word addresses. A request carries a 16-bit register list, a base address and three control bits: `pre_i` (step the base before the first access), `up_i` (move the base upward) and `wb_i` (request a base update). When the block is idle and sees `start_i`, it captures the request, counts the set bits of the list, and works out both the address of the first word and the updated base value.

It then offers one transfer per cycle on a valid/ready handshake. Each transfer carries a register index and its word address. Registers always go out lowest index first, at rising word addresses, whatever the addressing mode. When the last transfer is accepted, the block gives a one-cycle `done_o` pulse. In the same cycle it shows the writeback request and the new base value. Moving the data, writing the register file and handling aborts are left to the surrounding pipeline.

Top module: `block_xfer_seq`

## Requirements
- R1: With pre_i=0 and up_i=1, the first address equals the base.
- R2: With pre_i=1 and up_i=1, the first address equals the base plus 4.
- R3: With pre_i=0 and up_i=0, the first address equals the base minus 4·N plus 4, where N is the number of set bits in the list.
- R4: With pre_i=1 and up_i=0, the first address equals the base minus 4·N.
- R5: Transfers go out in ascending register index (bit k of the list is index k). Each accepted transfer is followed by an address exactly 4 higher, modulo 2^32.
- R6: While xfer_valid_o is high and xfer_ready_i is low, the valid flag, the address and the index hold unchanged.
- R7: During the done pulse, wb_en_o equals the captured wb_i. When it is set, wb_value_o is the base plus 4·N if up_i=1, or the base minus 4·N if up_i=0. wb_en_o is never high outside the done pulse.
- R8: An all-zero register list issues no transfer and raises done_o in the cycle after the start is captured.
- R9: A start_i that arrives while transfers are outstanding is ignored.
- R10: done_o is high for exactly one cycle, in the cycle after the final transfer is accepted, and never together with xfer_valid_o.
- R11: After reset, xfer_valid_o, done_o and wb_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| reg_list_i | input | 16 | Register list, bit k selects register k |
| base_i | input | 32 | Base address |
| pre_i | input | 1 | 1 = step before access, 0 = step after |
| up_i | input | 1 | 1 = ascending base, 0 = descending |
| wb_i | input | 1 | Request base writeback |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_ready_i | input | 1 | Consumer accepts the offered transfer |
| xfer_addr_o | output | 32 | Word address of the offered transfer |
| xfer_idx_o | output | 4 | Register index of the offered transfer |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Writeback requested, valid with done_o |
| wb_value_o | output | 32 | New base value, valid with done_o |

## Verification
A wrong population count or a wrong mode decode shows up at the ports in the first offered address, one cycle after the start. It also shows in the writeback value during the done pulse. A corrupted remaining-list mask shows in the next offered index, or as a done pulse that comes too early or too late, within one accepted transfer. A broken handshake hold shows in the first stalled cycle as a changed index or address.

// File: rtl/bts_pkg.sv
package bts_pkg;
  // Addressing mode as {pre, up}
  typedef enum logic [1:0] {
    MODE_DEC_AFTER  = 2'b00,
    MODE_INC_AFTER  = 2'b01,
    MODE_DEC_BEFORE = 2'b10,
    MODE_INC_BEFORE = 2'b11
  } xfer_mode_e;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/bts_popcount.sv
module bts_popcount #(
  parameter int NREG = 16,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] vec_i,
  output logic [CW-1:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/bts_lowest_set.sv
module bts_lowest_set #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec_i,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  // Scan from the top down so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/bts_addr_calc.sv
module bts_addr_calc
  import bts_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pre_i,
  input  logic          up_i,
  output logic [AW-1:0] first_addr_o,
  output logic [AW-1:0] new_base_o
);
  logic [AW-1:0] bytes;
  logic [AW-1:0] word;
  xfer_mode_e    mode;

  assign bytes = AW'(cnt_i) * AW'(WORD_BYTES);
  assign word  = AW'(WORD_BYTES);
  assign mode  = xfer_mode_e'({pre_i, up_i});

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  first_addr_o = base_i;
      MODE_INC_BEFORE: first_addr_o = base_i + word;
      MODE_DEC_AFTER:  first_addr_o = base_i - bytes + word;
      MODE_DEC_BEFORE: first_addr_o = base_i - bytes;
      default:         first_addr_o = base_i;
    endcase
    new_base_o = up_i ? (base_i + bytes) : (base_i - bytes);
  end
endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq
  import bts_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            pre_i,
  input  logic            up_i,
  input  logic            wb_i,
  output logic            xfer_valid_o,
  input  logic            xfer_ready_i,
  output logic [AW-1:0]   xfer_addr_o,
  output logic [IW-1:0]   xfer_idx_o,
  output logic            done_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_value_o
);
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr, new_base;
  logic [IW-1:0]   first_idx, next_idx;
  logic            first_any, next_any;
  logic [NREG-1:0] mask_q, mask_rest;
  logic [AW-1:0]   addr_q, wbv_q;
  logic [IW-1:0]   idx_q;
  logic            valid_q, done_q, wb_en_q, wb_pend_q;
  logic            accept;

  bts_popcount #(.NREG(NREG)) u_cnt (.vec_i(reg_list_i), .cnt_o(cnt));

  bts_addr_calc #(.NREG(NREG), .AW(AW)) u_calc (
    .base_i(base_i), .cnt_i(cnt), .pre_i(pre_i), .up_i(up_i),
    .first_addr_o(first_addr), .new_base_o(new_base)
  );

  bts_lowest_set #(.NREG(NREG)) u_first (
    .vec_i(reg_list_i), .idx_o(first_idx), .any_o(first_any)
  );

  assign mask_rest = mask_q & ~(NREG'(1) << idx_q);

  bts_lowest_set #(.NREG(NREG)) u_next (
    .vec_i(mask_rest), .idx_o(next_idx), .any_o(next_any)
  );

  assign accept = valid_q && xfer_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      addr_q    <= '0;
      idx_q     <= '0;
      wbv_q     <= '0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_pend_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      if (!valid_q) begin
        if (start_i) begin
          mask_q    <= reg_list_i;
          addr_q    <= first_addr;
          idx_q     <= first_idx;
          wbv_q     <= new_base;
          wb_pend_q <= wb_i;
          valid_q   <= first_any;
          if (!first_any) begin
            done_q  <= 1'b1;
            wb_en_q <= wb_i;
          end
        end
      end else if (accept) begin
        mask_q <= mask_rest;
        addr_q <= addr_q + AW'(WORD_BYTES);
        idx_q  <= next_idx;
        if (!next_any) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
          wb_en_q <= wb_pend_q;
        end
      end
    end
  end

  assign xfer_valid_o = valid_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_idx_o   = idx_q;
  assign done_o       = done_q;
  assign wb_en_o      = wb_en_q;
  assign wb_value_o   = wbv_q;

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + AW'(WORD_BYTES)));

  assert_idx_ascend_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && xfer_ready_i) |=> (!xfer_valid_o || xfer_idx_o > $past(xfer_idx_o)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_idx_o)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !xfer_valid_o);

  assert_wb_in_done_R7: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> done_o);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && start_i && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_idx_o)));
endmodule

// File: tb/block_xfer_seq_tb.sv
module block_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] reg_list_i = '0;
  logic [31:0] base_i = '0;
  logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0;
  logic        xfer_valid_o, xfer_ready_i = 1'b0;
  logic [31:0] xfer_addr_o, wb_value_o;
  logic [3:0]  xfer_idx_o;
  logic        done_o, wb_en_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  block_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .reg_list_i(reg_list_i),
    .base_i(base_i), .pre_i(pre_i), .up_i(up_i), .wb_i(wb_i),
    .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_addr_o(xfer_addr_o), .xfer_idx_o(xfer_idx_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Directed sequence: stall inserts ready gaps, poke issues a start while busy
  task automatic run_seq(input string tag, input logic [15:0] lst, input logic [31:0] base,
                         input bit p, input bit u, input bit w, input bit stall, input bit poke);
    int n = 0;
    int k = 0;
    int bit_pos = 0;
    logic [31:0] exp_addr, exp_wb;
    for (int i = 0; i < 16; i++) if (lst[i]) n++;
    case ({p, u})
      2'b01: exp_addr = base;
      2'b11: exp_addr = base + 32'd4;
      2'b00: exp_addr = base - 32'(4 * n) + 32'd4;
      default: exp_addr = base - 32'(4 * n);
    endcase
    exp_wb = u ? base + 32'(4 * n) : base - 32'(4 * n);
    @(negedge clk);
    reg_list_i = lst; base_i = base; pre_i = p; up_i = u; wb_i = w; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (k < n) begin
        while (!lst[bit_pos]) bit_pos++;
        chk(xfer_valid_o === 1'b1, {tag, " R5 valid"}, 32'(xfer_valid_o), 32'd1);
        chk(xfer_addr_o === exp_addr, {tag, " R5 addr"}, xfer_addr_o, exp_addr);
        chk(xfer_idx_o === 4'(bit_pos), {tag, " R5 idx"}, 32'(xfer_idx_o), 32'(bit_pos));
        chk(done_o === 1'b0, {tag, " R10 early done"}, 32'(done_o), 32'd0);
        xfer_ready_i = !(stall && (cyc % 2 == 1));
        if (poke && cyc == 1) begin
          reg_list_i = 16'h0001; base_i = 32'hDEAD0000; start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        if (xfer_ready_i) begin
          k++; bit_pos++; exp_addr = exp_addr + 32'd4;
        end
        xfer_ready_i = 1'b0;
      end else begin
        chk(done_o === 1'b1, {tag, " R10/R8 done"}, 32'(done_o), 32'd1);
        chk(xfer_valid_o === 1'b0, {tag, " R10 no valid"}, 32'(xfer_valid_o), 32'd0);
        chk(wb_en_o === w, {tag, " R7 wb_en"}, 32'(wb_en_o), 32'(w));
        if (w) chk(wb_value_o === exp_wb, {tag, " R7 wb_value"}, wb_value_o, exp_wb);
        @(negedge clk);
        chk(done_o === 1'b0, {tag, " R10 pulse width"}, 32'(done_o), 32'd0);
        chk(wb_en_o === 1'b0, {tag, " R7 wb_en after done"}, 32'(wb_en_o), 32'd0);
        break;
      end
    end
  endtask

  task automatic test_hold_R6();
    logic [31:0] a0;
    logic [3:0]  i0;
    @(negedge clk);
    reg_list_i = 16'h0030; base_i = 32'h200; pre_i = 1'b0; up_i = 1'b1; wb_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; a0 = xfer_addr_o; i0 = xfer_idx_o;
    repeat (3) @(negedge clk);
    chk(xfer_valid_o === 1'b1, "R6 valid held", 32'(xfer_valid_o), 32'd1);
    chk(xfer_addr_o === a0, "R6 addr held", xfer_addr_o, a0);
    chk(xfer_idx_o === i0, "R6 idx held", 32'(xfer_idx_o), 32'(i0));
    xfer_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    xfer_ready_i = 1'b0;
    chk(done_o === 1'b1, "R6 drain done", 32'(done_o), 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(xfer_valid_o === 1'b0, "R11 valid", 32'(xfer_valid_o), 32'd0);
    chk(done_o === 1'b0, "R11 done", 32'(done_o), 32'd0);
    chk(wb_en_o === 1'b0, "R11 wb_en", 32'(wb_en_o), 32'd0);
    rst = 1'b0;
    run_seq("R1 inc-after", 16'h8421, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_seq("R2 inc-before", 16'h00FF, 32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_seq("R3 dec-after", 16'hF00F, 32'h0000_3000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_seq("R4 dec-before", 16'h0001, 32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_seq("R4 full wrap", 16'hFFFF, 32'h0000_0030, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_seq("R3 no-wb", 16'h0A50, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_seq("R8 empty", 16'h0000, 32'h0000_5000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_seq("R9 busy start", 16'h0F0F, 32'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    test_hold_R6();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule